// File: doc/BRIEF.md
# Descriptor-chain DMA channel engine

This block is a single transmit or receive channel of a DMA engine. The channel follows a linked list of buffer descriptors kept in a small local descriptor memory. Software loads descriptors through a memory port. It then writes the address of the first descriptor to the head pointer register. The engine works down the chain one descriptor at a time. The data transfer itself is represented by a fixed delay of `XFER_LAT` cycles. When a descriptor completes, the engine clears its hardware-ownership flag, writes the length back, and reports the descriptor's address through the completion pointer. Software acknowledges each completion by writing the same address back. The interrupt line stays high until that acknowledgement arrives.

A teardown command stops the channel. The engine stamps the descriptor it is working on with a teardown-complete flag and reports a fixed sentinel through the completion pointer. A self-clearing soft reset returns every pointer to zero. A receive channel also keeps a count of free buffers. It only starts a descriptor while that count is nonzero.

Top module: `dchan_engine`

## Requirements
- R1: After reset, every register reads 0, `irq` is low and every descriptor memory word reads 0. Register addresses: 0 control, 1 soft reset, 2 head pointer, 3 completion pointer, 4 teardown, 5 free-buffer count, 6 status.
- R2: Bit 0 of the control register (address 0) is the enable bit. A nonzero write to the head pointer (address 2) while the engine is idle and enabled starts the engine at that descriptor. While enable is 0, the write has no effect. Reading address 2 returns the descriptor currently being worked on, or 0 when idle.
- R3: Descriptor n sits at byte address 16·n, and its word k is memory word 4·n+k. The words are: 0 next pointer, 1 buffer address, 2 offset (bits 31:16) and length (bits 10:0), 3 mode. On completion the engine rewrites the mode word as follows: bit 29 (hardware-owned) cleared, bit 27 cleared, bits 10:0 set to the length field of word 2, bit 28 (end of queue) set only when the next pointer is 0. All other bits are kept. The engine then follows the next pointer, or goes idle when it is 0.
- R4: The completion pointer (address 3) reads the address of the last descriptor completed. `irq` is high whenever that value differs from the value software last wrote to address 3.
- R5: A head pointer write while the engine is busy has no effect.
- R6: The engine skips a descriptor whose mode bit 29 is clear. It leaves that descriptor unmodified and moves to its next pointer. Skipping sets status bit 1 (address 6, bit 0 = busy). Any write to address 6 clears that bit.
- R7: Writing `CHAN_ID` to address 4 requests a teardown; any other value is ignored. A busy engine marks its current descriptor's mode with bit 27 and bit 28 set and bit 29 cleared, then goes idle. In every case the completion pointer then reads 0xFFFFFFFC, and `irq` stays high until software writes that value to address 3.
- R8: Writing 1 to bit 0 of address 1 starts a soft reset. Address 1 reads 1 for one cycle, then 0. The reset clears the head, completion and acknowledge pointers, the free-buffer count, the error bit and any pending teardown. The enable bit is kept.
- R9: In a receive channel, writing address 5 adds the written value to the free-buffer count. Each completion subtracts one, and both can happen in the same cycle. The engine waits before starting a descriptor while the count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_we | input | 1 | Descriptor memory write strobe |
| mem_addr | input | $clog2(4·NUM_DESC) | Descriptor memory word address |
| mem_wdata | input | 32 | Descriptor memory write data |
| mem_rdata | output | 32 | Descriptor memory read data (combinational) |
| irq | output | 1 | Completion interrupt |

## Verification
Two functions can meet in one cycle: a software write to the free-buffer count, and the decrement caused by a completing descriptor. The bench sets up a stalled receive descriptor and writes one buffer. It then times a second write so that it lands on exactly the edge where that descriptor completes, six edges after the first. The behavioural model, updated every clock, has to agree with the count read back on every cycle. The final count must equal the sum of both writes minus one.

// File: rtl/dchan_pkg.sv
package dchan_pkg;
   // mode word bit positions (decoded by software)
   localparam int SOP_B = 31;
   localparam int EOP_B = 30;
   localparam int OWN_B = 29;
   localparam int EOQ_B = 28;
   localparam int TDC_B = 27;
   localparam int CRC_B = 26;
   localparam int LEN_W = 11;
   localparam logic [31:0] TD_MARK = 32'hFFFF_FFFC;

   typedef enum logic [2:0] {
      RG_CTRL  = 3'd0,
      RG_SRST  = 3'd1,
      RG_HEAD  = 3'd2,
      RG_COMP  = 3'd3,
      RG_TDOWN = 3'd4,
      RG_FREE  = 3'd5,
      RG_STAT  = 3'd6
   } reg_sel_e;

   typedef enum logic [1:0] {W_IDLE, W_FETCH, W_XFER, W_DONE} walk_st_e;
endpackage

// File: rtl/dchan_desc_mem.sv
module dchan_desc_mem
   import dchan_pkg::*;
#(
   parameter  int NUM_DESC = 8,
   localparam int WORDS    = NUM_DESC * 4,
   localparam int WA_W     = $clog2(WORDS),
   localparam int IX_W     = $clog2(NUM_DESC)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sw_we,
   input  logic [WA_W-1:0]  sw_addr,
   input  logic [31:0]      sw_wdata,
   output logic [31:0]      sw_rdata,
   input  logic [IX_W-1:0]  eng_idx,
   output logic [31:0]      eng_next,
   output logic [LEN_W-1:0] eng_len,
   output logic [31:0]      eng_mode,
   input  logic             eng_we,
   input  logic [31:0]      eng_wdata
);
   logic [31:0] words [WORDS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < WORDS; i++) words[i] <= '0;
      end else begin
         if (sw_we) words[sw_addr] <= sw_wdata;
         // engine update is issued last so it wins a same-word collision
         if (eng_we) words[{eng_idx, 2'd3}] <= eng_wdata;
      end
   end

   assign sw_rdata = words[sw_addr];
   assign eng_next = words[{eng_idx, 2'd0}];
   assign eng_len  = words[{eng_idx, 2'd2}][LEN_W-1:0];
   assign eng_mode = words[{eng_idx, 2'd3}];
endmodule

// File: rtl/dchan_regs.sv
module dchan_regs
   import dchan_pkg::*;
#(
   parameter int CHAN_ID = 0,
   parameter bit IS_RX   = 1'b1,
   parameter int CNT_W   = 16
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        we,
   input  logic [2:0]  addr,
   input  logic [31:0] wdata,
   output logic [31:0] rdata,
   input  logic [31:0] cur_ptr,
   input  logic [31:0] done_ptr,
   input  logic        busy,
   input  logic        err,
   input  logic        take,
   output logic        en,
   output logic        srst_go,
   output logic        head_wr,
   output logic        td_req,
   output logic        err_clr,
   output logic [31:0] ack,
   output logic        buf_ok
);
   logic             srst_pend;
   logic             wr_ok;
   logic [CNT_W-1:0] free_cnt;

   assign wr_ok   = we && !srst_pend;
   assign srst_go = srst_pend;
   assign head_wr = wr_ok && (addr == RG_HEAD);
   assign td_req  = wr_ok && (addr == RG_TDOWN) && (wdata == 32'(CHAN_ID));
   assign err_clr = wr_ok && (addr == RG_STAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en        <= 1'b0;
         srst_pend <= 1'b0;
         ack       <= '0;
      end else if (srst_pend) begin
         srst_pend <= 1'b0;
         ack       <= '0;
      end else if (we) begin
         if (addr == RG_CTRL) en <= wdata[0];
         if (addr == RG_SRST && wdata[0]) srst_pend <= 1'b1;
         if (addr == RG_COMP) ack <= wdata;
      end
   end

   // R8
   // srst_clear_chk: a soft reset lasts exactly one cycle
   srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      srst_pend |=> !srst_pend);

   generate
      if (IS_RX) begin : g_rx
         logic [CNT_W-1:0] free_q;
         logic [CNT_W-1:0] add_v;
         assign add_v = (wr_ok && addr == RG_FREE) ? wdata[CNT_W-1:0] : '0;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         free_q <= '0;
            else if (srst_pend) free_q <= '0;
            else                free_q <= free_q + add_v - CNT_W'(take);
         end
         assign free_cnt = free_q;
         assign buf_ok   = (free_q != '0);
         // R9
         // free_floor_chk: a completion never consumes a buffer that is not there
         free_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
            take |-> free_q != '0);
      end else begin : g_tx
         assign free_cnt = '0;
         assign buf_ok   = 1'b1;
      end
   endgenerate

   always_comb begin
      unique case (addr)
         RG_CTRL: rdata = {31'b0, en};
         RG_SRST: rdata = {31'b0, srst_pend};
         RG_HEAD: rdata = cur_ptr;
         RG_COMP: rdata = done_ptr;
         RG_FREE: rdata = 32'(free_cnt);
         RG_STAT: rdata = {30'b0, err, busy};
         default: rdata = '0;
      endcase
   end
endmodule

// File: rtl/dchan_walker.sv
module dchan_walker
   import dchan_pkg::*;
#(
   parameter  int NUM_DESC = 8,
   parameter  int XFER_LAT = 4,
   localparam int IX_W     = $clog2(NUM_DESC),
   localparam int LW       = (XFER_LAT > 1) ? $clog2(XFER_LAT) : 1
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             srst_go,
   input  logic             en,
   input  logic             head_wr,
   input  logic [31:0]      head_val,
   input  logic             td_req,
   input  logic             err_clr,
   input  logic             buf_ok,
   input  logic [31:0]      d_next,
   input  logic [LEN_W-1:0] d_len,
   input  logic [31:0]      d_mode,
   output logic [IX_W-1:0]  d_idx,
   output logic             d_we,
   output logic [31:0]      d_wdata,
   output logic [31:0]      cur_ptr,
   output logic [31:0]      done_ptr,
   output logic             busy,
   output logic             err,
   output logic             take
);
   walk_st_e     st;
   logic [LW-1:0] cnt;
   logic         td_pend;
   logic         last_desc;
   logic         in_flight;

   assign d_idx     = cur_ptr[IX_W+3:4];
   assign last_desc = (d_next == '0);
   assign in_flight = (st == W_FETCH) || (st == W_XFER);
   assign busy      = (st != W_IDLE);
   assign take      = (st == W_DONE) && !srst_go;

   always_comb begin
      d_we    = 1'b0;
      d_wdata = d_mode;
      if (!srst_go) begin
         if (st == W_DONE) begin
            d_we                = 1'b1;
            d_wdata[OWN_B]      = 1'b0;
            d_wdata[TDC_B]      = 1'b0;
            d_wdata[EOQ_B]      = last_desc;
            d_wdata[LEN_W-1:0]  = d_len;
         end else if (td_pend && in_flight) begin
            d_we           = 1'b1;
            d_wdata[OWN_B] = 1'b0;
            d_wdata[EOQ_B] = 1'b1;
            d_wdata[TDC_B] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= W_IDLE; cnt <= '0; td_pend <= 1'b0; err <= 1'b0;
         cur_ptr <= '0; done_ptr <= '0;
      end else if (srst_go) begin
         st <= W_IDLE; cnt <= '0; td_pend <= 1'b0; err <= 1'b0;
         cur_ptr <= '0; done_ptr <= '0;
      end else begin
         if (err_clr) err <= 1'b0;
         unique case (st)
            W_IDLE: begin
               if (td_pend) begin
                  done_ptr <= TD_MARK;
                  td_pend  <= 1'b0;
               end else if (head_wr && en && head_val != '0) begin
                  cur_ptr <= head_val;
                  st      <= W_FETCH;
               end
            end
            W_FETCH, W_XFER: begin
               if (td_pend) begin
                  done_ptr <= TD_MARK;
                  td_pend  <= 1'b0;
                  cur_ptr  <= '0;
                  st       <= W_IDLE;
               end else if (st == W_XFER) begin
                  if (cnt == '0) st <= W_DONE;
                  else           cnt <= cnt - 1'b1;
               end else if (!d_mode[OWN_B]) begin
                  err     <= 1'b1;
                  cur_ptr <= d_next;
                  if (last_desc) st <= W_IDLE;
               end else if (buf_ok) begin
                  cnt <= LW'(XFER_LAT - 1);
                  st  <= W_XFER;
               end
            end
            W_DONE: begin
               done_ptr <= cur_ptr;
               cur_ptr  <= d_next;
               st       <= last_desc ? W_IDLE : W_FETCH;
            end
            default: st <= W_IDLE;
         endcase
         if (td_req) td_pend <= 1'b1;
      end
   end

   // R5
   // busy_head_chk: a head write during a transfer leaves the current pointer alone
   busy_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == W_XFER && head_wr && !td_pend && !srst_go) |=> cur_ptr == $past(cur_ptr));
   // R7
   // td_mark_chk: a serviced teardown always reports the sentinel
   td_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (td_pend && st != W_DONE && !srst_go) |=> done_ptr == TD_MARK);
   // R4
   // done_ptr_chk: completion reports the descriptor that just finished
   done_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == W_DONE && !srst_go) |=> done_ptr == $past(cur_ptr));
   // R2
   // en_gate_chk: with enable clear an idle engine stays idle
   en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == W_IDLE && !en && !srst_go) |=> st == W_IDLE);
endmodule

// File: rtl/dchan_engine.sv
module dchan_engine
   import dchan_pkg::*;
#(
   parameter  int NUM_DESC = 8,
   parameter  int XFER_LAT = 4,
   parameter  int CHAN_ID  = 0,
   parameter  bit IS_RX    = 1'b1,
   parameter  int CNT_W    = 16,
   localparam int WA_W     = $clog2(NUM_DESC * 4),
   localparam int IX_W     = $clog2(NUM_DESC)
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            reg_we,
   input  logic [2:0]      reg_addr,
   input  logic [31:0]     reg_wdata,
   output logic [31:0]     reg_rdata,
   input  logic            mem_we,
   input  logic [WA_W-1:0] mem_addr,
   input  logic [31:0]     mem_wdata,
   output logic [31:0]     mem_rdata,
   output logic            irq
);
   generate
      if (NUM_DESC < 2 || (NUM_DESC & (NUM_DESC - 1)) != 0) begin : g_bad_depth
         $error("NUM_DESC must be a power of two of at least 2");
      end
      if (XFER_LAT < 1) begin : g_bad_lat
         $error("XFER_LAT must be at least 1");
      end
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt
         $error("CNT_W must lie in 1..32");
      end
   endgenerate

   logic             en, srst_go, head_wr, td_req, err_clr, buf_ok;
   logic             busy, err, take, d_we;
   logic [31:0]      ack, cur_ptr, done_ptr, d_next, d_mode, d_wdata;
   logic [LEN_W-1:0] d_len;
   logic [IX_W-1:0]  d_idx;

   dchan_regs #(.CHAN_ID(CHAN_ID), .IS_RX(IS_RX), .CNT_W(CNT_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
      .rdata(reg_rdata), .cur_ptr(cur_ptr), .done_ptr(done_ptr), .busy(busy),
      .err(err), .take(take), .en(en), .srst_go(srst_go), .head_wr(head_wr),
      .td_req(td_req), .err_clr(err_clr), .ack(ack), .buf_ok(buf_ok));

   dchan_walker #(.NUM_DESC(NUM_DESC), .XFER_LAT(XFER_LAT)) u_walker (
      .clk(clk), .rst_n(rst_n), .srst_go(srst_go), .en(en), .head_wr(head_wr),
      .head_val(reg_wdata), .td_req(td_req), .err_clr(err_clr), .buf_ok(buf_ok),
      .d_next(d_next), .d_len(d_len), .d_mode(d_mode), .d_idx(d_idx),
      .d_we(d_we), .d_wdata(d_wdata), .cur_ptr(cur_ptr), .done_ptr(done_ptr),
      .busy(busy), .err(err), .take(take));

   dchan_desc_mem #(.NUM_DESC(NUM_DESC)) u_mem (
      .clk(clk), .rst_n(rst_n), .sw_we(mem_we), .sw_addr(mem_addr),
      .sw_wdata(mem_wdata), .sw_rdata(mem_rdata), .eng_idx(d_idx),
      .eng_next(d_next), .eng_len(d_len), .eng_mode(d_mode),
      .eng_we(d_we), .eng_wdata(d_wdata));

   assign irq = (done_ptr != ack);
endmodule

// File: tb/dchan_engine_bench.sv
`timescale 1ns/1ps
module dchan_engine_bench;
   localparam int          LAT  = 4;
   localparam logic [31:0] MARK = 32'hFFFF_FFFC;
   localparam logic [31:0] OWN  = 32'h2000_0000;
   localparam logic [31:0] EOQ  = 32'h1000_0000;
   localparam logic [31:0] TDC  = 32'h0800_0000;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        reg_we = 1'b0, mem_we = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0, mem_wdata = '0, reg_rdata, mem_rdata;
   logic [4:0]  mem_addr = '0;
   logic        irq;
   int          n_chk = 0, n_fail = 0;
   bit          run = 1'b0, finished = 1'b0;

   always #2.5 clk = ~clk;

   dchan_engine u_dchan_engine (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .irq(irq));

   // behavioural reference model
   logic [31:0] m_mem [32];
   logic        m_en = 0, m_srst = 0, m_td = 0, m_err = 0;
   int          m_st = 0, m_cnt = 0;
   logic [31:0] m_cur = 0, m_done = 0, m_ack = 0, m_free = 0;
   logic [31:0] nx, md, ln;
   int          ix;
   bit          took;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 32; i++) m_mem[i] = '0;
         m_en = 0; m_srst = 0; m_td = 0; m_err = 0; m_st = 0; m_cnt = 0;
         m_cur = 0; m_done = 0; m_ack = 0; m_free = 0;
      end else begin
         ix = int'((m_cur >> 4) & 7);
         nx = m_mem[ix*4]; ln = m_mem[ix*4+2]; md = m_mem[ix*4+3];
         if (mem_we) m_mem[mem_addr] = mem_wdata;
         if (m_srst) begin
            m_srst = 0; m_cur = 0; m_done = 0; m_ack = 0; m_free = 0;
            m_err = 0; m_td = 0; m_st = 0; m_cnt = 0;
         end else begin
            took = 0;
            if (reg_we && reg_addr == 6) m_err = 0;
            if (m_st == 0) begin
               if (m_td) begin m_done = MARK; m_td = 0; end
               else if (reg_we && reg_addr == 2 && m_en && reg_wdata != 0) begin
                  m_cur = reg_wdata; m_st = 1;
               end
            end else if (m_st == 3) begin
               m_mem[ix*4+3] = (md & ~(OWN | EOQ | TDC | 32'h7FF)) |
                               ((nx == 0) ? EOQ : 0) | (ln & 32'h7FF);
               m_done = m_cur; took = 1; m_cur = nx; m_st = (nx == 0) ? 0 : 1;
            end else if (m_td) begin
               m_mem[ix*4+3] = (md & ~OWN) | EOQ | TDC;
               m_done = MARK; m_td = 0; m_cur = 0; m_st = 0;
            end else if (m_st == 2) begin
               if (m_cnt == 0) m_st = 3; else m_cnt--;
            end else if ((md & OWN) == 0) begin
               m_err = 1; m_cur = nx; if (nx == 0) m_st = 0;
            end else if (m_free != 0) begin
               m_cnt = LAT - 1; m_st = 2;
            end
            if (reg_we) begin
               if (reg_addr == 0) m_en = reg_wdata[0];
               if (reg_addr == 1 && reg_wdata[0]) m_srst = 1;
               if (reg_addr == 3) m_ack = reg_wdata;
               if (reg_addr == 5) m_free = m_free + (reg_wdata & 32'hFFFF);
            end
            if (took) m_free = m_free - 1;
            m_free = m_free & 32'hFFFF;
            if (reg_we && reg_addr == 4 && reg_wdata == 0) m_td = 1;
         end
      end
   end

   function automatic logic [31:0] exp_read(logic [2:0] a);
      case (a)
         3'd0: return {31'b0, m_en};
         3'd1: return {31'b0, m_srst};
         3'd2: return m_cur;
         3'd3: return m_done;
         3'd5: return m_free;
         3'd6: return {30'b0, m_err, m_st != 0};
         default: return 0;
      endcase
   endfunction

   task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && run && !finished) begin
         check(irq == (m_done != m_ack), "R4 model irq", 32'(irq), 32'(m_done != m_ack));
         check(reg_rdata == exp_read(reg_addr), "R9 model register read", reg_rdata, exp_read(reg_addr));
         check(mem_rdata == m_mem[mem_addr], "R3 model memory read", mem_rdata, m_mem[mem_addr]);
      end
   end

   task automatic rwr(logic [2:0] a, logic [31:0] d);
      @(negedge clk); reg_we <= 1'b1; reg_addr <= a; reg_wdata <= d;
      @(negedge clk); reg_we <= 1'b0;
   endtask

   task automatic mwr(int a, logic [31:0] d);
      @(negedge clk); mem_we <= 1'b1; mem_addr <= 5'(a); mem_wdata <= d;
      @(negedge clk); mem_we <= 1'b0;
   endtask

   task automatic put_desc(int n, logic [31:0] nxt, logic [31:0] w2, logic [31:0] mode);
      mwr(4*n, nxt); mwr(4*n+1, 32'h1000 * n); mwr(4*n+2, w2); mwr(4*n+3, mode);
   endtask

   task automatic expect_reg(logic [2:0] a, logic [31:0] e, string tag);
      @(negedge clk); reg_addr <= a;
      @(negedge clk); check(reg_rdata == e, tag, reg_rdata, e);
   endtask

   task automatic expect_mem(int a, logic [31:0] e, string tag);
      @(negedge clk); mem_addr <= 5'(a);
      @(negedge clk); check(mem_rdata == e, tag, mem_rdata, e);
   endtask

   task automatic expect_irq(bit e, string tag);
      @(negedge clk); check(irq == e, tag, 32'(irq), 32'(e));
   endtask

   task automatic wait_cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL R2 watchdog act=running exp=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      wait_cyc(3);
      rst_n <= 1'b1; run <= 1'b1;
      // R1 reset state
      for (int a = 0; a < 7; a++) expect_reg(3'(a), 0, "R1 register after reset");
      expect_irq(0, "R1 irq after reset");
      expect_mem(7, 0, "R1 memory after reset");

      put_desc(1, 32'h20, 32'h0000_0040, 32'hE400_0000);
      put_desc(2, 32'h00, 32'h0005_0123, 32'hE000_0000);
      // R2 head write with enable clear is ignored
      rwr(2, 32'h10);
      expect_reg(2, 0, "R2 head ignored while disabled");
      expect_reg(6, 0, "R2 not busy while disabled");
      rwr(0, 1);
      rwr(5, 1);
      rwr(2, 32'h10);
      wait_cyc(14);
      expect_mem(7, 32'hC400_0040, "R3 first descriptor handed back");
      expect_reg(3, 32'h10, "R4 completion pointer");
      expect_irq(1, "R4 irq pending");
      expect_reg(2, 32'h20, "R9 waits for a free buffer");
      expect_reg(6, 1, "R9 busy while waiting");
      // R5 head write while busy
      rwr(2, 32'h30);
      expect_reg(2, 32'h20, "R5 busy head write ignored");
      // R9 free-count write coinciding with a completion
      rwr(5, 1);
      wait_cyc(4);
      rwr(5, 3);
      wait_cyc(4);
      expect_reg(5, 3, "R9 same-cycle add and take");
      expect_mem(11, 32'hD000_0123, "R3 last descriptor gets end of queue");
      expect_reg(3, 32'h20, "R4 completion pointer advances");
      expect_reg(2, 0, "R3 idle after end of chain");
      rwr(3, 32'h20);
      expect_irq(0, "R4 irq cleared by acknowledge");

      // R6 skip of a descriptor owned by software
      put_desc(3, 32'h40, 32'h0000_0008, 32'h0000_0000);
      put_desc(4, 32'h00, 32'h0000_0010, 32'h2000_0000);
      rwr(2, 32'h30);
      wait_cyc(14);
      expect_mem(15, 32'h0000_0000, "R6 skipped descriptor untouched");
      expect_mem(19, 32'h1000_0010, "R6 next descriptor completed");
      expect_reg(6, 2, "R6 error flag set");
      rwr(6, 0);
      expect_reg(6, 0, "R6 error flag cleared");
      expect_reg(3, 32'h40, "R4 completion after skip");
      rwr(3, 32'h40);

      // R7 teardown
      rwr(4, 7);
      expect_reg(3, 32'h40, "R7 wrong channel number ignored");
      expect_irq(0, "R7 no irq after wrong number");
      put_desc(5, 32'h00, 32'h0000_0020, 32'h2000_0000);
      rwr(2, 32'h50);
      rwr(4, 0);
      wait_cyc(10);
      expect_mem(23, 32'h1800_0000, "R7 descriptor marked torn down");
      expect_reg(3, MARK, "R7 sentinel in completion pointer");
      expect_irq(1, "R7 irq until sentinel written back");
      expect_reg(5, 2, "R7 no buffer consumed by teardown");
      rwr(3, MARK);
      expect_irq(0, "R7 irq cleared by sentinel");

      // R8 soft reset
      rwr(3, 1);
      expect_irq(1, "R8 irq before soft reset");
      @(negedge clk); reg_we <= 1'b1; reg_addr <= 3'd1; reg_wdata <= 1;
      @(negedge clk); reg_we <= 1'b0;
      check(reg_rdata == 1, "R8 soft reset reads one", reg_rdata, 1);
      @(negedge clk);
      check(reg_rdata == 0, "R8 soft reset self-clears", reg_rdata, 0);
      expect_reg(3, 0, "R8 completion pointer cleared");
      expect_reg(5, 0, "R8 free count cleared");
      expect_reg(0, 1, "R8 enable kept");
      expect_irq(0, "R8 irq cleared");

      wait_cyc(2);
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule